// File: doc/BRIEF.md
# Maskable Vectored Interrupt Controller

This block gathers interrupt events from external pins, internal peripheral strobes and a software break. It keeps one latched request bit per source. A request is raised to the CPU only when its enable bit is set and the global disable flag is clear. Among the eligible sources, a fixed-priority encoder picks one and presents its vector index. The CPU takes the interrupt by raising an acknowledge line. That acceptance clears the chosen request and sets the global disable flag. The index then stays frozen until the CPU drops acknowledge. Pushing state and fetching the vector remain on the CPU side.

External inputs pass through a synchronizer and then an edge detector. A per-input polarity bit chooses the rising or the falling edge. Edges are taken from the polarity-adjusted level, so rewriting a polarity bit while the pin is steady can itself latch a request. Software therefore disables the source, changes the polarity, clears the request and only then re-enables it. The software break ignores every mask.

Top module: `intr_ctrl`

## Requirements
- R1: A maskable source raises `irq_o` only when its request bit and enable bit are both 1 and the disable flag is 0; otherwise it stays pending without raising `irq_o`.
- R2: A register write to the request register (address 0) clears each request bit where the written data is 0 and leaves every bit where the data is 1 unchanged; software can never set a request.
- R3: A pulse on `brk_i` latches a break that raises `irq_o` with vector index 16 regardless of the disable flag and all enable bits.
- R4: Priority is fixed: break first, then source 0, source 1 and so on up to source 14; `vec_o` carries the winning source number.
- R5: When `ack_i` is high at a clock edge while `irq_o` is high, that source is accepted. Acceptance clears its request bit (or the latched break), sets the disable flag and pulses `accept_o` for the following cycle.
- R6: External input k (k = 0..3, request bit k) is synchronized. Its request is set on the rising edge when polarity bit k (address 2) is 0, and on the falling edge when it is 1. The bit reads as set three clock edges after the pin changes, and the opposite edge sets nothing.
- R7: A polarity write that flips the adjusted level of a steady input sets that input's request one edge after the write takes effect; a level of 0 with polarity changed from 0 to 1 is one case.
- R8: From acceptance until `ack_i` is sampled low, `irq_o` stays 0 and `vec_o` holds the accepted index. Requests arriving in that window compete at the first arbitration after `ack_i` falls.
- R9: Register map: 0 request, 1 enable, 2 polarity in bits 3:0, 3 disable flag in bit 0. Bit 15 of the request and enable registers always reads 0. After reset every register reads 0 except the disable flag, which reads 1.
- R10: Internal strobe `int_i[j]` high at a clock edge sets request bit 4+j at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ext_i | input | 4 | Asynchronous external interrupt pins (sources 0..3) |
| int_i | input | 11 | Internal event strobes (sources 4..14) |
| brk_i | input | 1 | Software break strobe |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data (combinational) |
| irq_o | output | 1 | Interrupt pending to CPU |
| vec_o | output | 5 | Vector index of winner or accepted source |
| ack_i | input | 1 | CPU acknowledge, held high for the service window |
| accept_o | output | 1 | One-cycle pulse after an acceptance |

## Verification
Register writes, strobes and acknowledges are applied on one edge and are visible at the falling edge after it, since each passes through a single register. External pins pass through three register stages and are read after the third edge. A polarity rewrite shows up one edge after the write edge. The bench drives inputs on falling edges and samples each result at the falling edge in which it is due. Reads use the combinational read port after a short settle delay. Randomized enable and request patterns are checked against a lowest-index winner computed in the bench.

// File: rtl/intr_pkg.sv
package intr_pkg;
  typedef enum logic [1:0] {
    RA_REQ = 2'd0,
    RA_EN  = 2'd1,
    RA_POL = 2'd2,
    RA_DIS = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/intr_edge.sv
module intr_edge #(
  parameter int N_EXT = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_EXT-1:0] lvl_i,
  input  logic [N_EXT-1:0] pol_i,
  output logic [N_EXT-1:0] evt_o
);
  for (genvar k = 0; k < N_EXT; k++) begin : g_in
    logic s1_q, s2_q, adj_q;
    logic adj;
    // edge is taken on the polarity-adjusted level
    assign adj = s2_q ^ pol_i[k];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q  <= 1'b0;
        s2_q  <= 1'b0;
        adj_q <= 1'b0;
      end else begin
        s1_q  <= lvl_i[k];
        s2_q  <= s1_q;
        adj_q <= adj;
      end
    end
    assign evt_o[k] = adj & ~adj_q;
  end
endmodule

// File: rtl/intr_prio.sv
module intr_prio #(
  parameter int N_SRC = 16,
  parameter int IDX_W = 5
) (
  input  logic [N_SRC-1:0] cand_i,
  input  logic             brk_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    any_o = brk_i | (|cand_i);
    idx_o = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (cand_i[i]) idx_o = IDX_W'(i);
    end
    if (brk_i) idx_o = IDX_W'(N_SRC);
  end
endmodule

// File: rtl/intr_ctrl.sv
module intr_ctrl
  import intr_pkg::*;
#(
  parameter int N_SRC = 16,
  parameter int N_EXT = 4,
  localparam int IDX_W = $clog2(N_SRC + 1),
  localparam int SRC_W = $clog2(N_SRC),
  localparam int N_INT = N_SRC - 1 - N_EXT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_EXT-1:0] ext_i,
  input  logic [N_INT-1:0] int_i,
  input  logic             brk_i,
  input  logic             reg_we_i,
  input  logic [1:0]       reg_addr_i,
  input  logic [N_SRC-1:0] reg_wdata_i,
  output logic [N_SRC-1:0] reg_rdata_o,
  output logic             irq_o,
  output logic [IDX_W-1:0] vec_o,
  input  logic             ack_i,
  output logic             accept_o
);
  localparam logic [N_SRC-1:0] LIVE_MASK = {1'b0, {(N_SRC-1){1'b1}}};
  localparam logic [IDX_W-1:0] BRK_IDX   = IDX_W'(N_SRC);

  reg_addr_e        ra;
  logic [N_SRC-1:0] req_q, req_d, en_q, cand, src_evt;
  logic [N_EXT-1:0] pol_q, ext_evt;
  logic             dis_q, brk_q, busy_q, accept_q;
  logic [IDX_W-1:0] vec_q, win_idx;
  logic             any_win, take, take_brk;
  logic             wr_req, wr_en, wr_pol, wr_dis;

  assign ra     = reg_addr_e'(reg_addr_i);
  assign wr_req = reg_we_i && (ra == RA_REQ);
  assign wr_en  = reg_we_i && (ra == RA_EN);
  assign wr_pol = reg_we_i && (ra == RA_POL);
  assign wr_dis = reg_we_i && (ra == RA_DIS);

  intr_edge #(.N_EXT(N_EXT)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (ext_i),
    .pol_i (pol_q),
    .evt_o (ext_evt)
  );

  assign src_evt = {1'b0, int_i, ext_evt};
  assign cand    = req_q & en_q & {N_SRC{~dis_q}};

  intr_prio #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_prio (
    .cand_i(cand),
    .brk_i (brk_q),
    .any_o (any_win),
    .idx_o (win_idx)
  );

  assign irq_o    = any_win & ~busy_q;
  assign take     = ack_i & irq_o;
  assign take_brk = take && (win_idx == BRK_IDX);
  assign vec_o    = busy_q ? vec_q : win_idx;
  assign accept_o = accept_q;

  // new events win over clears in the same cycle
  always_comb begin
    req_d = req_q;
    if (wr_req) req_d = req_d & reg_wdata_i;
    if (take && !take_brk) req_d[win_idx[SRC_W-1:0]] = 1'b0;
    req_d = (req_d | src_evt) & LIVE_MASK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q    <= '0;
      en_q     <= '0;
      pol_q    <= '0;
      dis_q    <= 1'b1;
      brk_q    <= 1'b0;
      busy_q   <= 1'b0;
      vec_q    <= '0;
      accept_q <= 1'b0;
    end else begin
      req_q    <= req_d;
      accept_q <= take;
      if (wr_en)  en_q  <= reg_wdata_i & LIVE_MASK;
      if (wr_pol) pol_q <= reg_wdata_i[N_EXT-1:0];
      if (take)        dis_q <= 1'b1;
      else if (wr_dis) dis_q <= reg_wdata_i[0];
      if (brk_i)         brk_q <= 1'b1;
      else if (take_brk) brk_q <= 1'b0;
      if (take) begin
        busy_q <= 1'b1;
        vec_q  <= win_idx;
      end else if (!ack_i) begin
        busy_q <= 1'b0;
      end
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (ra)
      RA_REQ: reg_rdata_o = req_q;
      RA_EN:  reg_rdata_o = en_q;
      RA_POL: reg_rdata_o[N_EXT-1:0] = pol_q;
      RA_DIS: reg_rdata_o[0] = dis_q;
      default: reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/intr_ctrl_chk.sv
module intr_ctrl_chk #(
  parameter int N_SRC = 16,
  parameter int IDX_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             irq_o,
  input logic [IDX_W-1:0] vec_o,
  input logic             ack_i,
  input logic             accept_o,
  input logic [N_SRC-1:0] req_q,
  input logic [N_SRC-1:0] en_q,
  input logic             dis_q,
  input logic             brk_q,
  input logic             busy_q
);
  localparam int SRC_W = $clog2(N_SRC);
  localparam logic [IDX_W-1:0] BRK_IDX = IDX_W'(N_SRC);

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !brk_q) |-> (!dis_q && req_q[vec_o[SRC_W-1:0]] && en_q[vec_o[SRC_W-1:0]])); // R1

  AST_BRK_UNMASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brk_q && !busy_q) |-> (irq_o && vec_o == BRK_IDX)); // R3

  AST_ACCEPT_DISABLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> dis_q); // R5

  AST_VEC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && ack_i) |=> (!irq_o && $stable(vec_o))); // R8

  AST_TOP_BIT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q[N_SRC-1] && !req_q[N_SRC-1])); // R9
endmodule

bind intr_ctrl intr_ctrl_chk #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .irq_o   (irq_o),
  .vec_o   (vec_o),
  .ack_i   (ack_i),
  .accept_o(accept_o),
  .req_q   (req_q),
  .en_q    (en_q),
  .dis_q   (dis_q),
  .brk_q   (brk_q),
  .busy_q  (busy_q)
);

// File: tb/intr_ctrl_test.sv
`timescale 1ns/1ps
module intr_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  ext_i = '0;
  logic [10:0] int_i = '0;
  logic        brk_i = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_addr_i = '0;
  logic [15:0] reg_wdata_i = '0;
  logic [15:0] reg_rdata_o;
  logic        irq_o;
  logic [4:0]  vec_o;
  logic        ack_i = 1'b0;
  logic        accept_o;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  intr_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .ext_i(ext_i), .int_i(int_i), .brk_i(brk_i),
    .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .irq_o(irq_o), .vec_o(vec_o), .ack_i(ack_i),
    .accept_o(accept_o)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    tick();
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    reg_addr_i = a;
    #1;
    d = reg_rdata_o;
  endtask

  task automatic pulse_int(input logic [10:0] p);
    int_i = p;
    tick();
    int_i = '0;
  endtask

  function automatic int exp_win(input logic [15:0] pend);
    for (int i = 0; i < 16; i++) if (pend[i]) return i;
    return 0;
  endfunction

  initial begin
    #1_500_000;
    bad++;
    total++;
    $display("FAIL watchdog all-reqs actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] d, en, exq;
    logic [10:0] p;
    int w;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R9 reset state
    rd(0, d); chk("R9 reset req", d, 0);
    rd(1, d); chk("R9 reset en", d, 0);
    rd(2, d); chk("R9 reset pol", d, 0);
    rd(3, d); chk("R9 reset dis", d, 1);
    chk("R9 reset irq", irq_o, 0);
    wr(1, 16'hFFFF); rd(1, d); chk("R9 en bit15 reads 0", d, 16'h7FFF);

    // R10 internal strobes
    pulse_int(11'h005); rd(0, d); chk("R10 int strobe sets req", d, 16'h0050);
    // R2 write ones has no effect, zeros clear
    wr(0, 16'hFFFF); rd(0, d); chk("R2 write ones keeps", d, 16'h0050);
    wr(0, 16'hFFEF); rd(0, d); chk("R2 write zero clears", d, 16'h0040);
    wr(0, 16'h0000);
    wr(0, 16'hFFFF); rd(0, d); chk("R2 never sets", d, 0);

    // R1 masking
    wr(1, 16'h0000); pulse_int(11'h001); wr(3, 0);
    chk("R1 no irq when disabled en", irq_o, 0);
    wr(1, 16'h0010); chk("R1 irq when enabled", irq_o, 1);
    chk("R4 vec src4", vec_o, 4);
    wr(3, 1); chk("R1 no irq when dis flag", irq_o, 0);
    wr(3, 0);

    // R4 break outranks, R5 acceptance of break
    brk_i = 1'b1; tick(); brk_i = 1'b0;
    chk("R4 break wins", vec_o, 16);
    ack_i = 1'b1; tick();
    chk("R5 accept pulse", accept_o, 1);
    rd(3, d); chk("R5 dis set", d, 1);
    rd(0, d); chk("R5 other req kept", d, 16'h0010);
    tick(); chk("R5 accept one cycle", accept_o, 0);
    ack_i = 1'b0; tick();
    chk("R1 pending masked by dis", irq_o, 0);
    // R3 break with all masks active
    wr(1, 16'h0000);
    brk_i = 1'b1; tick(); brk_i = 1'b0;
    chk("R3 break irq", irq_o, 1); chk("R3 break vec", vec_o, 16);
    ack_i = 1'b1; tick(); ack_i = 1'b0; tick();
    chk("R3 break cleared", irq_o, 0);

    // R8 acknowledge window
    wr(0, 0); wr(1, 16'h0220);
    pulse_int(11'h020); wr(3, 0);
    chk("R8 pre vec", vec_o, 9);
    ack_i = 1'b1; tick();
    rd(0, d); chk("R5 accepted req cleared", d, 0);
    wr(3, 0); pulse_int(11'h002);
    chk("R8 irq low in window", irq_o, 0);
    chk("R8 vec held", vec_o, 9);
    ack_i = 1'b0; tick();
    chk("R8 irq after release", irq_o, 1);
    chk("R8 new winner", vec_o, 5);
    ack_i = 1'b1; tick(); ack_i = 1'b0; tick();

    // R6 rising edge on ext0
    wr(0, 0); wr(1, 0);
    ext_i[0] = 1'b1; tick(); tick();
    rd(0, d); chk("R6 not yet after two edges", d, 0);
    tick(); rd(0, d); chk("R6 rising sets", d, 16'h0001);
    wr(0, 0);
    ext_i[0] = 1'b0; repeat (4) tick();
    rd(0, d); chk("R6 falling ignored pol0", d, 0);
    // R7 polarity rewrite hazard on ext3 (pin low)
    wr(2, 16'h0008); tick();
    rd(0, d); chk("R7 pol change sets req", d, 16'h0008);
    wr(0, 0);
    ext_i[3] = 1'b1; repeat (4) tick();
    rd(0, d); chk("R6 rising ignored pol1", d, 0);
    ext_i[3] = 1'b0; repeat (3) tick();
    rd(0, d); chk("R6 falling sets pol1", d, 16'h0008);
    wr(0, 0);

    // random patterns, R4 R5 R10
    for (int it = 0; it < 40; it++) begin
      wr(0, 0);
      en = 16'($urandom) & 16'h7FFF;
      wr(1, en);
      p = 11'($urandom);
      pulse_int(p);
      exq = {1'b0, p, 4'b0};
      rd(0, d); chk("R10 random req", d, exq);
      wr(3, 0);
      chk("R1 random irq", irq_o, (|(exq & en)) ? 1 : 0);
      if (|(exq & en)) begin
        w = exp_win(exq & en);
        chk("R4 random vec", vec_o, w);
        ack_i = 1'b1; tick();
        chk("R5 random accept", accept_o, 1);
        chk("R8 random vec hold", vec_o, w);
        rd(0, d); chk("R5 random clear", d, exq & ~(16'h1 << w));
        rd(3, d); chk("R5 random dis", d, 1);
        ack_i = 1'b0; tick();
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule